// File: doc/BRIEF.md
# Ethernet receive frame queue

The block takes received Ethernet frames as a byte stream and files each one into its own slot of a circular store of 31 slots. It writes the payload into the slot starting at byte offset 2. Once the last byte is in, it appends the frame check value and pads the final 32-bit word with zeros. It then writes a 16-bit length at the start of the slot. The length counts the payload plus the 2-byte prefix plus the 4-byte check value. Frames that arrive while the queue is disabled, while every slot is occupied, or that are too large for a slot are swallowed without being stored.

A processor drains the queue through a small register port. Each read of the data register returns the next 32-bit word of the oldest stored frame, packed little-endian. When the remaining length of that frame is used up, its slot is released and the next read starts on the following slot. A control register enables reception and flushes the queue. A write-one-to-clear status register holds three flags: frame stored, frame too long, and read while empty. The interrupt output is the OR of those flags. The number of occupied slots is driven out on its own port.

The byte input is valid/ready. A byte moves only on a clock edge where both `s_valid` and `s_ready` are high. The sender must hold `s_data` and `s_last` stable while `s_valid` is high and `s_ready` is low. The block drops `s_ready` for the trailer cycles of every stored frame: four check bytes, the padding and two length bytes. It keeps `s_ready` high while it discards a dropped frame.

Top module: `rx_frame_queue`

## Requirements
- R1: The queue holds at most SLOTS (31) frames, and `frame_count` never exceeds SLOTS. Frames leave in arrival order, and after slot 30 is drained reading continues with slot 0.
- R2: Data word k of a stored frame holds slot bytes 4k..4k+3, with byte 4k in bits 7:0. Bytes 0 and 1 of the slot hold the length, low byte first, and that length equals the payload byte count plus 6. The payload follows from byte 2 on.
- R3: The four bytes directly after the payload carry the bitwise complement of a reflected CRC-32. The CRC uses polynomial 0xEDB88320, is preset to all ones and runs over the payload only, and its bytes are stored low byte first.
- R4: Bytes that follow the check value within the last 32-bit word of a frame read as zero.
- R5: A frame that starts while the enable bit (control bit 0) is clear, or while all SLOTS slots are occupied, is consumed with `s_ready` high and not stored. `frame_count` and status bit 0 stay unchanged.
- R6: The first data read (register address 2) of a frame returns word 0 and loads the remaining length from the stored length. Every data read returns the next word and lowers the remaining length by 4.
- R7: The data read that brings the remaining length to zero or below retires the frame. `frame_count` drops by one, and the next data read returns word 0 of the following frame.
- R8: A control write with bit 1 set empties the queue (`frame_count` becomes 0). It also abandons a partly read frame and any frame being stored.
- R9: Storing a frame sets status bit 0 (register address 0), which raises `irq`.
- R10: A data read while the queue is empty returns 0 and sets status bit 2. It leaves `frame_count` unchanged.
- R11: A frame whose payload count plus 6 exceeds SLOT_BYTES (128 by default) is not stored and sets status bit 1. A payload of exactly SLOT_BYTES-6 bytes is stored.
- R12: Writing the status register clears each status bit written as 1. `reg_rdata` shows the value of a read one clock after `reg_rd` and holds it until the next read. Reading the control register returns the enable bit in bit 0.
- R13: In the clock after the last byte of a stored frame is accepted, `s_ready` is low. It stays low until the frame has been committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Received byte is valid |
| s_ready | output | 1 | Block accepts a byte this cycle |
| s_data | input | 8 | Received byte |
| s_last | input | 1 | Marks the final byte of a frame |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 control, 2 data |
| reg_wdata | input | 3 | Write data (status clear mask, or control bits) |
| reg_rdata | output | 32 | Read data, one clock after the read strobe |
| irq | output | 1 | OR of the status flags |
| frame_count | output | 5 | Number of occupied slots |

## Verification
The assertions assume that a single clock never carries both a register read and a register write. The bench issues each access as its own one-cycle strobe, so this always holds. They also assume the byte stream obeys the valid/ready hold rule. The bench changes the stream inputs only after it has seen `s_ready` high and a clock edge pass. Payload lengths are drawn between 1 and the slot limit, except for the deliberate oversize frame, and flushes happen only between stream transfers.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [2:0] {
    W_IDLE,
    W_STORE,
    W_DROP,
    W_CRC,
    W_PAD,
    W_LEN
  } wr_state_t;

  localparam logic [1:0] RA_STATUS = 2'd0;
  localparam logic [1:0] RA_CTRL   = 2'd1;
  localparam logic [1:0] RA_DATA   = 2'd2;
endpackage

// File: rtl/rxq_crc32.sv
module rxq_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        first,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  function automatic logic [31:0] step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  logic [31:0] seed;
  assign seed = first ? 32'hFFFF_FFFF : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) crc_q <= 32'hFFFF_FFFF;
    else if (en) crc_q <= step(seed, din);
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 992,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [1:0]    wlane,
  input  logic [7:0]    wbyte,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rword
);
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] rq;
    always_ff @(posedge clk) begin
      if (we && wlane == 2'(l)) mem[waddr] <= wbyte;
      if (re) rq <= mem[raddr];
    end
    assign rword[8*l +: 8] = rq;
  end
endmodule

// File: rtl/rxq_writer.sv
module rxq_writer
  import rxq_pkg::*;
#(
  parameter int SLOTS = 31,
  parameter int SLOT_BYTES = 128,
  localparam int SW = $clog2(SLOTS),
  localparam int OB = $clog2(SLOT_BYTES),
  localparam int LW = OB + 1,
  localparam int AW = SW + OB - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  input  logic          enable,
  input  logic          room,
  input  logic          flush,
  input  logic [SW-1:0] slot_in,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_lane,
  output logic [7:0]    mem_byte,
  output logic          commit,
  output logic [SW-1:0] commit_slot,
  output logic [LW-1:0] commit_len,
  output logic          too_long
);
  wr_state_t     state;
  logic [LW-1:0] nbytes;
  logic [OB-1:0] wptr;
  logic [OB-1:0] wnext;
  logic [1:0]    cidx;
  logic [SW-1:0] wslot;
  logic          take;
  logic          start_ok;
  logic          too_big;
  logic [LW:0]   need;
  logic [15:0]   len16;
  logic [31:0]   crc_q;
  logic [31:0]   crc_fin;
  logic          crc_en;
  logic          crc_first;
  logic [OB-1:0] off;
  logic [SW-1:0] slot_sel;

  assign s_ready  = (state == W_IDLE) || (state == W_STORE) || (state == W_DROP);
  assign take     = s_valid && s_ready;
  assign start_ok = enable && room && !flush;
  assign need     = {1'b0, nbytes} + (LW+1)'(7);
  assign too_big  = need > (LW+1)'(SLOT_BYTES);
  assign len16    = 16'(nbytes) + 16'd6;
  assign crc_fin  = ~crc_q;
  assign wnext    = wptr + OB'(1);

  rxq_crc32 u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (crc_en),
    .first(crc_first),
    .din  (s_data),
    .crc_q(crc_q)
  );

  always_comb begin
    mem_we    = 1'b0;
    off       = wptr;
    mem_byte  = s_data;
    slot_sel  = wslot;
    crc_en    = 1'b0;
    crc_first = 1'b0;
    case (state)
      W_IDLE: if (take && start_ok) begin
        mem_we    = 1'b1;
        off       = OB'(2);
        slot_sel  = slot_in;
        crc_en    = 1'b1;
        crc_first = 1'b1;
      end
      W_STORE: if (take && !flush && !too_big) begin
        mem_we = 1'b1;
        crc_en = 1'b1;
      end
      W_CRC: begin
        mem_we   = !flush;
        mem_byte = crc_fin[8*cidx +: 8];
      end
      W_PAD: begin
        mem_we   = !flush;
        mem_byte = 8'd0;
      end
      W_LEN: begin
        mem_we   = !flush;
        off      = OB'(cidx[0]);
        mem_byte = cidx[0] ? len16[15:8] : len16[7:0];
      end
      default: ;
    endcase
  end

  assign mem_addr    = {slot_sel, off[OB-1:2]};
  assign mem_lane    = off[1:0];
  assign commit      = (state == W_LEN) && cidx[0] && !flush;
  assign commit_slot = wslot;
  assign commit_len  = LW'(len16);
  assign too_long    = (state == W_STORE) && take && !flush && too_big;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= W_IDLE;
      nbytes <= '0;
      wptr   <= '0;
      cidx   <= '0;
      wslot  <= '0;
    end else begin
      case (state)
        W_IDLE: if (take) begin
          if (start_ok) begin
            wslot  <= slot_in;
            nbytes <= LW'(1);
            wptr   <= OB'(3);
            cidx   <= '0;
            state  <= s_last ? W_CRC : W_STORE;
          end else if (!s_last) begin
            state <= W_DROP;
          end
        end
        W_STORE: if (take) begin
          if (flush || too_big) begin
            state <= s_last ? W_IDLE : W_DROP;
          end else begin
            nbytes <= nbytes + LW'(1);
            wptr   <= wnext;
            if (s_last) begin
              cidx  <= '0;
              state <= W_CRC;
            end
          end
        end
        W_DROP: if (take && s_last) state <= W_IDLE;
        W_CRC: begin
          if (flush) state <= W_IDLE;
          else begin
            wptr <= wnext;
            cidx <= cidx + 2'd1;
            if (cidx == 2'd3) begin
              cidx  <= '0;
              state <= (wnext[1:0] == 2'd0) ? W_LEN : W_PAD;
            end
          end
        end
        W_PAD: begin
          if (flush) state <= W_IDLE;
          else begin
            wptr <= wnext;
            if (wnext[1:0] == 2'd0) begin
              cidx  <= '0;
              state <= W_LEN;
            end
          end
        end
        W_LEN: begin
          if (flush) state <= W_IDLE;
          else begin
            cidx <= cidx + 2'd1;
            if (cidx[0]) state <= W_IDLE;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  // R5: a frame is only committed while a free slot exists
  p_commit_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> room);
  // R2 / R11: committed length covers prefix and check value and fits a slot
  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_len >= LW'(7)) && ({1'b0, commit_len} <= (LW+1)'(SLOT_BYTES)));
  // R13: the trailer holds off the stream
  p_trailer_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (state == W_STORE && take && s_last && !flush && !too_big) |=> !s_ready);
endmodule

// File: rtl/rxq_reader.sv
module rxq_reader #(
  parameter int SLOTS = 31,
  parameter int SLOT_BYTES = 128,
  localparam int SW = $clog2(SLOTS),
  localparam int OB = $clog2(SLOT_BYTES),
  localparam int LW = OB + 1,
  localparam int WB = OB - 2,
  localparam int CW = $clog2(SLOTS + 1),
  localparam int AW = SW + WB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          flush,
  input  logic [CW-1:0] count,
  input  logic          commit,
  input  logic [SW-1:0] commit_slot,
  input  logic [LW-1:0] commit_len,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          retire,
  output logic          underflow,
  output logic [SW-1:0] rd_slot
);
  logic [LW-1:0] lens [SLOTS];
  logic          active;
  logic [LW-1:0] rem;
  logic [WB-1:0] word;
  logic [LW-1:0] cur_len;

  always_ff @(posedge clk) begin
    if (commit) lens[commit_slot] <= commit_len;
  end

  assign cur_len   = lens[rd_slot];
  assign re        = req && !flush && (active || count != '0);
  assign underflow = req && !flush && !active && count == '0;
  assign retire    = re && (active ? (rem <= LW'(4)) : (cur_len <= LW'(4)));
  assign raddr     = {rd_slot, active ? word : WB'(0)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rem     <= '0;
      word    <= '0;
      rd_slot <= '0;
    end else if (flush) begin
      active <= 1'b0;
    end else if (re) begin
      if (retire) begin
        active  <= 1'b0;
        rd_slot <= (rd_slot == SW'(SLOTS - 1)) ? '0 : rd_slot + SW'(1);
      end else if (!active) begin
        active <= 1'b1;
        rem    <= cur_len - LW'(4);
        word   <= WB'(1);
      end else begin
        rem  <= rem - LW'(4);
        word <= word + WB'(1);
      end
    end
  end

  // R1: read slot stays inside the ring
  p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_slot <= SW'(SLOTS - 1));
  // R7: a frame is retired only from an occupied queue
  p_retire_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> count != '0);
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
  import rxq_pkg::*;
#(
  parameter int SLOTS = 31,
  parameter int SLOT_BYTES = 128,
  localparam int SW = $clog2(SLOTS),
  localparam int OB = $clog2(SLOT_BYTES),
  localparam int LW = OB + 1,
  localparam int CW = $clog2(SLOTS + 1),
  localparam int AW = SW + OB - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [2:0]    reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic [CW-1:0] frame_count
);
  logic          enable_q;
  logic [2:0]    status_q;
  logic [CW-1:0] count;
  logic          flush;
  logic          room;
  logic [SW-1:0] rd_slot;
  logic [SW-1:0] wslot;
  logic [SW:0]   wsum;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_lane;
  logic [7:0]    mem_byte;
  logic          commit;
  logic [SW-1:0] commit_slot;
  logic [LW-1:0] commit_len;
  logic          too_long;
  logic          rd_req;
  logic          re;
  logic [AW-1:0] raddr;
  logic          retire;
  logic          underflow;
  logic [31:0]   rword;
  logic          sel_data_q;
  logic [31:0]   hold_q;
  logic [2:0]    st_set;
  logic [2:0]    st_clr;

  assign flush  = reg_wr && reg_addr == RA_CTRL && reg_wdata[1];
  assign rd_req = reg_rd && reg_addr == RA_DATA;
  assign room   = count < CW'(SLOTS);
  assign wsum   = {1'b0, rd_slot} + (SW+1)'(count);
  assign wslot  = (wsum >= (SW+1)'(SLOTS)) ? SW'(wsum - (SW+1)'(SLOTS)) : wsum[SW-1:0];

  rxq_writer #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_writer (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_valid    (s_valid),
    .s_data     (s_data),
    .s_last     (s_last),
    .s_ready    (s_ready),
    .enable     (enable_q),
    .room       (room),
    .flush      (flush),
    .slot_in    (wslot),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_lane   (mem_lane),
    .mem_byte   (mem_byte),
    .commit     (commit),
    .commit_slot(commit_slot),
    .commit_len (commit_len),
    .too_long   (too_long)
  );

  rxq_store #(.DEPTH(SLOTS << (OB - 2))) u_store (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_addr),
    .wlane(mem_lane),
    .wbyte(mem_byte),
    .re   (re),
    .raddr(raddr),
    .rword(rword)
  );

  rxq_reader #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_reader (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (rd_req),
    .flush      (flush),
    .count      (count),
    .commit     (commit),
    .commit_slot(commit_slot),
    .commit_len (commit_len),
    .re         (re),
    .raddr      (raddr),
    .retire     (retire),
    .underflow  (underflow),
    .rd_slot    (rd_slot)
  );

  assign st_set = {underflow, too_long, commit};
  assign st_clr = (reg_wr && reg_addr == RA_STATUS) ? reg_wdata : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q   <= 1'b0;
      status_q   <= '0;
      count      <= '0;
      sel_data_q <= 1'b0;
      hold_q     <= '0;
    end else begin
      status_q <= (status_q & ~st_clr) | st_set;
      if (reg_wr && reg_addr == RA_CTRL) enable_q <= reg_wdata[0];
      if (flush) count <= '0;
      else count <= count + CW'(commit) - CW'(retire);
      if (reg_rd) begin
        sel_data_q <= rd_req && re;
        case (reg_addr)
          RA_STATUS: hold_q <= {29'd0, status_q};
          RA_CTRL:   hold_q <= {31'd0, enable_q};
          default:   hold_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata   = sel_data_q ? rword : hold_q;
  assign irq         = |status_q;
  assign frame_count = count;

  // R1: occupancy bound
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(SLOTS));
  // R8: flush empties the queue
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
  // R9: a stored frame raises the interrupt
  p_commit_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq && status_q[0]);
  // R11: oversize frame flags an error
  p_oversize_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    too_long |=> status_q[1]);
  // R10: empty read flags underflow and leaves occupancy alone
  p_underflow_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !commit) |=> status_q[2] && count == $past(count));
endmodule

// File: tb/test_rx_frame_queue.sv
module test_rx_frame_queue;
  localparam int SLOTS = 31;
  localparam int SB = 128;
  localparam int MAXP = SB - 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = 8'd0;
  logic        s_last = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [2:0]  reg_wdata = 3'd0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [4:0]  frame_count;

  always #2 clk = ~clk;

  rx_frame_queue #(.SLOTS(SLOTS), .SLOT_BYTES(SB)) i_rx_frame_queue (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .frame_count(frame_count)
  );

  int unsigned total = 0;
  int unsigned fails = 0;
  bit done = 1'b0;
  logic [7:0] pay [SB];
  logic [7:0] mq [SLOTS][SB];
  int mn [SLOTS];
  int mhead = 0;
  int msize = 0;
  logic [31:0] rv;
  int unsigned seedv;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_of(input int s);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < mn[s]; i++) begin
      c = c ^ {24'd0, mq[s][i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [31:0] exp_word(input int s, input int k);
    logic [31:0] w = '0;
    logic [31:0] cf = crc_of(s);
    int n = mn[s];
    for (int b = 0; b < 4; b++) begin
      int p = 4*k + b;
      logic [7:0] v;
      if (p == 0) v = 8'((n + 6) & 255);
      else if (p == 1) v = 8'((n + 6) >> 8);
      else if (p < n + 2) v = mq[s][p-2];
      else if (p < n + 6) v = cf[8*(p-n-2) +: 8];
      else v = 8'd0;
      w[8*b +: 8] = v;
    end
    return w;
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [2:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic fill_pay(input int n);
    for (int i = 0; i < n; i++) pay[i] = 8'($urandom_range(0, 255));
  endtask

  task automatic send_frame(input int n, input bit stored);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_data = pay[i]; s_last = (i == n - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
    if (stored) check(!s_ready, "R13 ready low after last byte", {31'd0, s_ready}, 32'd0);
    while (!s_ready) @(negedge clk);
    if (stored) begin
      int idx = (mhead + msize) % SLOTS;
      for (int i = 0; i < n; i++) mq[idx][i] = pay[i];
      mn[idx] = n;
      msize++;
    end
  endtask

  task automatic drain_one(input string tag);
    int nw = (mn[mhead] + 6 + 3) / 4;
    for (int k = 0; k < nw; k++) begin
      logic [31:0] e = exp_word(mhead, k);
      reg_read(2'd2, rv);
      check(rv == e, tag, rv, e);
    end
    mhead = (mhead + 1) % SLOTS;
    msize--;
    check(frame_count == 5'(msize), "R7 count after retire", {27'd0, frame_count}, 32'(msize));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    seedv = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(frame_count == 0, "R1 reset count", {27'd0, frame_count}, 0);
    check(irq == 0, "R9 reset irq", {31'd0, irq}, 0);
    check(s_ready == 1, "R13 reset ready", {31'd0, s_ready}, 1);
    reg_read(2'd0, rv);
    check(rv == 0, "R12 reset status", rv, 0);

    reg_read(2'd2, rv);
    check(rv == 0, "R10 empty read returns zero", rv, 0);
    reg_read(2'd0, rv);
    check(rv == 32'd4, "R10 underflow flag", rv, 4);
    check(frame_count == 0, "R10 count unchanged", {27'd0, frame_count}, 0);
    reg_write(2'd0, 3'b100);
    reg_read(2'd0, rv);
    check(rv == 0, "R12 write-one clears", rv, 0);

    fill_pay(10);
    send_frame(10, 1'b0);
    check(frame_count == 0, "R5 disabled drop", {27'd0, frame_count}, 0);
    reg_read(2'd0, rv);
    check(rv == 0, "R5 disabled no status", rv, 0);

    reg_write(2'd1, 3'b001);
    reg_read(2'd1, rv);
    check(rv == 1, "R12 control readback", rv, 1);

    for (int n = 1; n <= 5; n++) begin
      fill_pay(n);
      send_frame(n, 1'b1);
      check(frame_count == 5'(msize), "R9 count after store", {27'd0, frame_count}, 32'(msize));
    end
    check(irq == 1, "R9 irq after store", {31'd0, irq}, 1);
    reg_read(2'd0, rv);
    check(rv == 1, "R9 stored flag", rv, 1);
    while (msize > 0) drain_one("R2 R3 R4 R6 short frame word");
    reg_write(2'd0, 3'b111);

    for (int f = 0; f < SLOTS; f++) begin
      int n = $urandom_range(1, MAXP);
      fill_pay(n);
      send_frame(n, 1'b1);
    end
    check(frame_count == 5'(SLOTS), "R1 full count", {27'd0, frame_count}, SLOTS);
    reg_write(2'd0, 3'b111);
    fill_pay(20);
    send_frame(20, 1'b0);
    check(frame_count == 5'(SLOTS), "R5 full drop", {27'd0, frame_count}, SLOTS);
    reg_read(2'd0, rv);
    check(rv == 0, "R5 full no status", rv, 0);
    while (msize > 0) drain_one("R1 R3 ring frame word");
    for (int f = 0; f < 6; f++) begin
      int n = $urandom_range(1, MAXP);
      fill_pay(n);
      send_frame(n, 1'b1);
    end
    while (msize > 0) drain_one("R1 wrapped frame word");

    reg_write(2'd0, 3'b111);
    fill_pay(MAXP + 1);
    send_frame(MAXP + 1, 1'b0);
    check(frame_count == 0, "R11 oversize dropped", {27'd0, frame_count}, 0);
    reg_read(2'd0, rv);
    check(rv == 32'd2, "R11 oversize flag", rv, 2);
    fill_pay(MAXP);
    send_frame(MAXP, 1'b1);
    check(frame_count == 1, "R11 max frame stored", {27'd0, frame_count}, 1);
    drain_one("R11 max frame word");

    fill_pay(30); send_frame(30, 1'b1);
    fill_pay(9);  send_frame(9, 1'b1);
    reg_read(2'd2, rv);
    check(rv == exp_word(mhead, 0), "R6 first word before flush", rv, exp_word(mhead, 0));
    reg_write(2'd1, 3'b011);
    check(frame_count == 0, "R8 flush empties", {27'd0, frame_count}, 0);
    msize = 0;
    fill_pay(13); send_frame(13, 1'b1);
    drain_one("R8 frame after flush word");
    reg_read(2'd2, rv);
    check(rv == 0, "R10 empty after drain", rv, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule